// File: doc/BRIEF.md
# Segmented Carry-Skip Adder

This block is a purely combinational adder. It adds two operands and a carry-in, and it produces a sum and a carry-out. The datapath is cut into four segments of unequal width. By default the segments are 4, 6, 18 and 4 bits wide, and together they give 32 bits. Within each segment, two ripple lanes precompute the sum: one lane assumes an incoming carry of 0 and the other assumes 1. The real incoming carry then picks one of the two lanes.

Each segment also forms a group propagate signal, which is true when every bit pair in the segment differs. When that signal is true, the incoming carry bypasses the segment's internal chain and leaves directly as the segment's carry-out. In every other case, the segment's carry-out is produced inside the segment and does not depend on the incoming carry. The carry path across the word is therefore a short chain of four multiplexers, not a ripple through every bit.

The four segment widths are parameters, and the total data width is derived from them. A smaller instance can therefore be built for exhaustive checking.

Top module: `csk_adder`

## Requirements
- R1: For all inputs, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` computed with WIDTH+1 bits.
- R2: Bit ranges by segment index, from the least significant bit upward: segment 0 is [3:0], segment 1 is [9:4], segment 2 is [27:10] and segment 3 is [31:28]. The carries between segments sit at bit positions 4, 10 and 28. The carry into a segment at bit position k equals bit k of the sum of the operand bits below k plus `cin_i`.
- R3: When every bit of a segment has `a_i` differing from `b_i`, that segment's carry-out equals its carry-in.
- R4: When at least one bit of a segment has `a_i` equal to `b_i`, that segment's carry-out does not depend on its carry-in. Sum bits above that segment and `cout_o` are therefore unchanged when the carry arriving at the segment toggles.
- R5: When `a_i` is the bitwise inverse of `b_i` across all bits, `cout_o` equals `cin_i`. In that case `sum_o` is all ones if `cin_i` is 0 and all zeros if `cin_i` is 1.
- R6: When both operands are all ones, `cout_o` is 1 and `sum_o` is all ones except bit 0, which equals `cin_i`.
- R7: When both operands are zero, `sum_o` equals `cin_i` zero-extended and `cout_o` is 0.
- R8: The segment widths SEG0_W..SEG3_W are parameters, and WIDTH is their sum. R1 holds for a small configuration with widths 2, 1, 3 and 2.
- R9: The outputs follow the inputs in the same time step, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds two instances. The first uses the default widths 4, 6, 18 and 4, and it receives boundary patterns at bit positions 0, 4, 10, 28 and 32, carry-kill patterns inside each segment, and random vectors. The second uses widths 2, 1, 3 and 2, which gives an 8-bit adder. That size makes every combination of operands and carry-in reachable, so each segment width, each skip path and each pair of lane choices is exercised against arithmetic computed in the bench.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Number of segments in the adder.
    localparam int NSEG = 4;

    // Lowest bit index of segment idx, given the four segment widths.
    function automatic int seg_lo(input int idx, input int w0, input int w1,
                                  input int w2, input int w3);
        int acc;
        acc = 0;
        if (idx > 0) acc += w0;
        if (idx > 1) acc += w1;
        if (idx > 2) acc += w2;
        if (idx > 3) acc += w3;
        return acc;
    endfunction

    // Per-segment carry summary.
    typedef struct packed {
        logic prop;   // every bit pair differs
        logic gen;    // carry produced inside the segment
    } csk_grp_t;

endpackage

// File: rtl/csk_ripple_chain.sv
module csk_ripple_chain #(
    parameter int   W       = 4,
    parameter logic CIN_VAL = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] carry_d;

    always_comb begin
        carry_d[0] = CIN_VAL;
        for (int i = 0; i < W; i++) begin
            sum_o[i]       = a_i[i] ^ b_i[i] ^ carry_d[i];
            carry_d[i+1]   = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & carry_d[i]);
        end
        cout_o = carry_d[W];
    end

endmodule

// File: rtl/csk_segment.sv
module csk_segment #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         grp_p_o
);

    logic [W-1:0] lane0_sum, lane1_sum;
    logic         lane0_cout, lane1_cout;
    csk_pkg::csk_grp_t grp_d;

    csk_ripple_chain #(.W(W), .CIN_VAL(1'b0)) lane0_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (lane0_sum),
        .cout_o(lane0_cout)
    );

    csk_ripple_chain #(.W(W), .CIN_VAL(1'b1)) lane1_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (lane1_sum),
        .cout_o(lane1_cout)
    );

    always_comb begin
        grp_d.prop = &(a_i ^ b_i);
        grp_d.gen  = cin_i ? lane1_cout : lane0_cout;
        sum_o      = cin_i ? lane1_sum : lane0_sum;
        cout_o     = grp_d.prop ? cin_i : grp_d.gen;
        grp_p_o    = grp_d.prop;
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int SEG0_W = 4,
    parameter int SEG1_W = 6,
    parameter int SEG2_W = 18,
    parameter int SEG3_W = 4,
    localparam int WIDTH = SEG0_W + SEG1_W + SEG2_W + SEG3_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NSEG = csk_pkg::NSEG;
    localparam int SEG_W [NSEG] = '{SEG0_W, SEG1_W, SEG2_W, SEG3_W};

    logic [NSEG:0]   carry_w;
    logic [NSEG-1:0] grp_p_w;

    assign carry_w[0] = cin_i;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = csk_pkg::seg_lo(k, SEG0_W, SEG1_W, SEG2_W, SEG3_W);
        localparam int W  = SEG_W[k];

        csk_segment #(.W(W)) seg_i (
            .a_i    (a_i[LO +: W]),
            .b_i    (b_i[LO +: W]),
            .cin_i  (carry_w[k]),
            .sum_o  (sum_o[LO +: W]),
            .cout_o (carry_w[k+1]),
            .grp_p_o(grp_p_w[k])
        );
    end

    assign cout_o = carry_w[NSEG];

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int SEG0_W = 4,
    parameter int SEG1_W = 6,
    parameter int SEG2_W = 18,
    parameter int SEG3_W = 4,
    localparam int WIDTH = SEG0_W + SEG1_W + SEG2_W + SEG3_W
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [4:0]       carry_w,
    input logic [3:0]       grp_p_w
);

    localparam int SEG_W [4] = '{SEG0_W, SEG1_W, SEG2_W, SEG3_W};
    localparam logic [WIDTH:0] ONE = 1;

    logic [WIDTH:0] full_sum;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        assert_sum_R1: assert ({cout_o, sum_o} == full_sum)
            else $error("R1 sum mismatch");
        if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
            assert_fullprop_R5: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
                else $error("R5 full propagate mismatch");
        end
    end

    for (genvar k = 0; k <= 4; k++) begin : g_bound
        localparam int LO = csk_pkg::seg_lo(k, SEG0_W, SEG1_W, SEG2_W, SEG3_W);
        localparam logic [WIDTH:0] LOW_MASK = (ONE << LO) - ONE;
        logic [WIDTH:0] part_sum;
        always_comb begin
            part_sum = ({1'b0, a_i} & LOW_MASK) + ({1'b0, b_i} & LOW_MASK)
                     + {{WIDTH{1'b0}}, cin_i};
            assert_boundary_carry_R2: assert (carry_w[k] == part_sum[LO])
                else $error("R2 boundary carry mismatch");
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_seg
        localparam int LO = csk_pkg::seg_lo(k, SEG0_W, SEG1_W, SEG2_W, SEG3_W);
        localparam int W  = SEG_W[k];
        localparam logic [WIDTH:0] SEG_MASK = (ONE << W) - ONE;
        logic [WIDTH:0] la, lb, ls;
        always_comb begin
            la = ({1'b0, a_i} >> LO) & SEG_MASK;
            lb = ({1'b0, b_i} >> LO) & SEG_MASK;
            ls = la + lb;
            if ((la ^ lb) == SEG_MASK) begin
                assert_skip_R3: assert (carry_w[k+1] == carry_w[k] && grp_p_w[k])
                    else $error("R3 skip path mismatch");
            end else begin
                assert_local_carry_R4: assert (carry_w[k+1] == ls[W] && !grp_p_w[k])
                    else $error("R4 local carry mismatch");
            end
        end
    end

endmodule

bind csk_adder csk_adder_chk #(
    .SEG0_W(SEG0_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SEG3_W(SEG3_W)
) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .carry_w(carry_w),
    .grp_p_w(grp_p_w)
);

// File: tb/csk_adder_tb_top.sv
module csk_adder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Default 32-bit instance
    logic [31:0] a_big, b_big, s_big;
    logic        c_big, co_big;

    csk_adder dut_i (
        .a_i(a_big), .b_i(b_big), .cin_i(c_big), .sum_o(s_big), .cout_o(co_big)
    );

    // Small 8-bit instance for exhaustive sweep (R8)
    logic [7:0] a_sm, b_sm, s_sm;
    logic       c_sm, co_sm;

    csk_adder #(.SEG0_W(2), .SEG1_W(1), .SEG2_W(3), .SEG3_W(2)) small_i (
        .a_i(a_sm), .b_i(b_sm), .cin_i(c_sm), .sum_o(s_sm), .cout_o(co_sm)
    );

    localparam int BLO [5] = '{0, 4, 10, 28, 32};

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_big(input string req, input logic [31:0] a,
                             input logic [31:0] b, input logic c);
        logic [32:0] exp;
        @(posedge clk);
        a_big = a; b_big = b; c_big = c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
        check(req, {co_big, s_big}, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        a_big = '0; b_big = '0; c_big = 1'b0;
        a_sm = '0; b_sm = '0; c_sm = 1'b0;

        // R7: zero operands, both carry values
        apply_big("R7 zero cin0", 32'd0, 32'd0, 1'b0);
        check("R7 zero sum", {co_big, s_big}, 33'd0);
        apply_big("R7 zero cin1", 32'd0, 32'd0, 1'b1);
        check("R7 zero sum cin", {co_big, s_big}, 33'd1);

        // R6: all ones plus all ones
        for (int c = 0; c < 2; c++) begin
            apply_big("R6 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, c[0]);
            check("R6 pattern", {co_big, s_big}, {1'b1, 31'h7FFF_FFFF, c[0]});
        end

        // R5: full propagate across all 32 bits
        for (int c = 0; c < 2; c++) begin
            apply_big("R5 full propagate", 32'hA5C3_0F96, 32'h5A3C_F069, c[0]);
            check("R5 pattern", {co_big, s_big}, c[0] ? {1'b1, 32'd0} : {1'b0, 32'hFFFF_FFFF});
            apply_big("R5 ones plus zero", 32'hFFFF_FFFF, 32'd0, c[0]);
        end

        // R2: carries landing exactly on segment boundaries
        for (int k = 0; k < 5; k++) begin
            logic [32:0] lowm;
            lowm = (33'd1 << BLO[k]) - 33'd1;
            apply_big("R2 boundary plus one", lowm[31:0], 32'd1, 1'b0);
            apply_big("R2 boundary cin", lowm[31:0], 32'd0, 1'b1);
            apply_big("R2 boundary all ones b", lowm[31:0], 32'hFFFF_FFFF, 1'b1);
            apply_big("R2 boundary bit", lowm[32:1] ^ 32'h0, lowm[31:0] ^ 32'h0, 1'b1);
        end

        // R3: carry skipping a fully propagating segment
        for (int k = 0; k < 4; k++) begin
            logic [32:0] upm;
            upm = (33'd1 << BLO[k+1]) - 33'd1;
            apply_big("R3 skip segment", upm[31:0], 32'd0, 1'b1);
            check("R3 skip carry lands", {co_big, s_big}, upm + 33'd1);
        end

        // R4: a kill bit at a segment's bottom isolates upper bits from incoming carry
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ra, rb, lowm32;
            logic [31:0] s0, s1;
            logic        co0, co1;
            int          top;
            top = BLO[k] + 1;
            lowm32 = (32'd1 << BLO[k]) - 32'd1;
            ra = $urandom();
            rb = $urandom();
            ra[BLO[k]] = 1'b0;
            rb[BLO[k]] = 1'b0;
            ra = (ra & ~lowm32) | lowm32;
            rb = rb & ~lowm32;
            apply_big("R4 kill cin0", ra, rb, 1'b0);
            s0 = s_big; co0 = co_big;
            apply_big("R4 kill cin1", ra, rb, 1'b1);
            s1 = s_big; co1 = co_big;
            check("R4 upper bits unchanged", {co1, s1 >> top}, {co0, s0 >> top});
        end

        // R1: random vectors
        for (int n = 0; n < 400; n++) begin
            apply_big("R1 random", $urandom(), $urandom(), 1'($urandom()));
        end

        // R9: outputs follow inputs between clock edges
        @(negedge clk);
        a_big = 32'h0000_FFFF; b_big = 32'h0000_0001; c_big = 1'b0;
        #1;
        check("R9 same step", {co_big, s_big}, 33'h0_0001_0000);
        a_big = 32'hFFFF_FFFF;
        #1;
        check("R9 same step change", {co_big, s_big}, 33'h1_0000_0000);

        // R8: exhaustive sweep of the 8-bit configuration
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] exp_s;
                    @(posedge clk);
                    a_sm = a[7:0]; b_sm = b[7:0]; c_sm = c[0];
                    #1;
                    exp_s = {1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, c[0]};
                    check("R8 small exhaustive", {24'd0, co_sm, s_sm}, {24'd0, exp_s});
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule